// File: doc/BRIEF.md
# VLAN Membership Table with Command Register

This block keeps a small table of VLAN entries and lets a host manage it through a handful of 16-bit registers. Each entry holds a valid flag, a 13-bit VLAN ID, an 8-bit database number and a 4-bit group per port. Within each group, bits 1:0 are the membership code and bits 3:2 are the forwarding state. The host first fills the VLAN ID and data registers. It then writes the command register with bit 15 set, which starts one operation.

Three operations are supported:
- **Load/purge** adds, replaces or removes one entry.
- **Flush** clears the whole table.
- **Get-next** returns the valid entry with the next higher VLAN ID. It copies that entry's fields back into the registers, so issuing the command again continues the walk.

The engine finds entries by scanning the table one slot per clock cycle. The command register shows the operation as busy until the scan has finished and the result has been committed.

Top module: `vlan_tbl`

## Requirements
- R1: A register write to address 0 with bit 15 set starts the operation selected by bits 14:12. Bit 15 of address 0 then reads 1 until that operation completes, and 0 afterwards.
- R2: The VLAN ID register (address 1) holds VID bits 11:0 in bits 11:0, a valid flag in bit 12, and VID bit 12 in bit 13. Data registers sit at addresses 2, 3 and 4. Port p uses bits 4*(p%4)+3 : 4*(p%4) of register 2+p/4. After reset every register reads 0.
- R3: Get-next (code 4) finds the valid entry with the lowest VID strictly greater than the VID in the register. It writes that VID back with the valid flag set, so repeating the command walks the table in increasing order.
- R4: On a hit, get-next returns the entry's database number in command register bits 3:0 (number bits 3:0) and bits 11:8 (number bits 7:4). It returns the entry's port groups in the data registers.
- R5: When no higher valid entry exists, get-next leaves the VID register reading 0x0FFF (valid clear). A search whose key is 0x0FFF (page 0) starts from the lowest valid entry.
- R6: Load/purge (code 3) with the valid flag set stores the entry. The database number comes from the start write, and the port groups from the data registers. With the flag clear, the command removes the entry with that VID.
- R7: Loading a VID already in the table overwrites that entry in place and creates no duplicate.
- R8: Loading a new VID into a full table leaves the table unchanged and sets bit 4 of the command register. A successful load or a flush clears that bit.
- R9: Flush (code 1) invalidates every entry.
- R10: Register writes are ignored while an operation is busy.
- R11: Any other operation code completes without changing the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data (combinational) |

## Verification
The bench builds the block with DEPTH=4 and NPORT=12. With four slots, the table fills after four loads, so the full-table rejection and its flag can be reached directly. The in-place overwrite and purge-then-reuse of a slot also become reachable. Twelve ports use all three data registers. The loaded VIDs include one with bit 12 set, so the page bit and the ordering across it are exercised during a full walk.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
  localparam int REGW = 16;
  localparam int VIDW = 13;
  localparam int DBW  = 8;

  localparam logic [2:0] OPC_FLUSH = 3'd1;
  localparam logic [2:0] OPC_LOAD  = 3'd3;
  localparam logic [2:0] OPC_NEXT  = 3'd4;

  localparam logic [2:0] A_OP   = 3'd0;
  localparam logic [2:0] A_VID  = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;

  localparam logic [VIDW-1:0] VID_WALK = 13'h0FFF;

  // database number is split across two nibbles of the command word
  function automatic logic [DBW-1:0] db_from_op(input logic [REGW-1:0] w);
    return {w[11:8], w[3:0]};
  endfunction

  function automatic logic [REGW-1:0] db_to_op(input logic [DBW-1:0] d);
    return {4'h0, d[7:4], 4'h0, d[3:0]};
  endfunction

  function automatic logic [VIDW-1:0] vid_from_reg(input logic [REGW-1:0] w);
    return {w[13], w[11:0]};
  endfunction

  function automatic logic [REGW-1:0] vid_to_reg(input logic [VIDW-1:0] v,
                                                 input logic vld);
    return {2'b00, v[12], vld, v[11:0]};
  endfunction

  // a key of VID_WALK restarts the walk from the bottom of the table
  function automatic logic vid_after(input logic [VIDW-1:0] cand,
                                     input logic [VIDW-1:0] key);
    return (key == VID_WALK) ? 1'b1 : (cand > key);
  endfunction
endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store
  import vlan_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 48,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic            we,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_vld,
  input  logic [VIDW-1:0] wr_vid,
  input  logic [DBW-1:0]  wr_db,
  input  logic [DW-1:0]   wr_dat,
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_vld,
  output logic [VIDW-1:0] rd_vid,
  output logic [DBW-1:0]  rd_db,
  output logic [DW-1:0]   rd_dat,
  output logic [DEPTH-1:0] vld_vec
);
  logic [DEPTH-1:0] vld_q;
  logic [VIDW-1:0]  vid_m [DEPTH];
  logic [DBW-1:0]   db_m  [DEPTH];
  logic [DW-1:0]    dat_m [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= '0;
    else if (clr_all) vld_q <= '0;
    else if (we)      vld_q[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (we && wr_vld) begin
      vid_m[wr_idx] <= wr_vid;
      db_m[wr_idx]  <= wr_db;
      dat_m[wr_idx] <= wr_dat;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_vid  = vid_m[rd_idx];
  assign rd_db   = db_m[rd_idx];
  assign rd_dat  = dat_m[rd_idx];
  assign vld_vec = vld_q;
endmodule

// File: rtl/vlan_tbl_scan.sv
module vlan_tbl_scan
  import vlan_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic [IW-1:0]   idx,
  input  logic            e_vld,
  input  logic [VIDW-1:0] e_vid,
  input  logic [VIDW-1:0] key,
  output logic            match_hit,
  output logic [IW-1:0]   match_idx,
  output logic            free_hit,
  output logic [IW-1:0]   free_idx,
  output logic            best_hit,
  output logic [IW-1:0]   best_idx,
  output logic [VIDW-1:0] best_vid
);
  logic is_match, is_free, is_better;

  assign is_match  = e_vld && (e_vid == key) && !match_hit;
  assign is_free   = !e_vld && !free_hit;
  assign is_better = e_vld && vid_after(e_vid, key) && (!best_hit || (e_vid < best_vid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      match_hit <= 1'b0; match_idx <= '0;
      free_hit  <= 1'b0; free_idx  <= '0;
      best_hit  <= 1'b0; best_idx  <= '0; best_vid <= '0;
    end else if (step) begin
      if (is_match)  begin match_hit <= 1'b1; match_idx <= idx; end
      if (is_free)   begin free_hit  <= 1'b1; free_idx  <= idx; end
      if (is_better) begin best_hit  <= 1'b1; best_idx  <= idx; best_vid <= e_vid; end
    end
  end
endmodule

// File: rtl/vlan_tbl.sv
module vlan_tbl
  import vlan_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NPORT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data
);
  localparam int NDREG = (NPORT + 3) / 4;
  localparam int DW    = NDREG * REGW;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_DONE} st_e;
  st_e st_q;

  logic [2:0]      opc_q;
  logic [DBW-1:0]  db_q;
  logic [VIDW-1:0] vid_q;
  logic            vflag_q;
  logic [DW-1:0]   data_q;
  logic            full_q;
  logic [IW-1:0]   idx_q;

  logic busy, host_wr, start_evt, commit_evt;
  logic load_wr, purge_wr, full_set, flush_evt, next_hit, next_miss;

  logic            match_hit, free_hit, best_hit;
  logic [IW-1:0]   match_idx, free_idx, best_idx, wr_idx, rd_idx;
  logic [VIDW-1:0] best_vid, e_vid;
  logic            e_vld;
  logic [DBW-1:0]  e_db;
  logic [DW-1:0]   e_dat;
  logic [DEPTH-1:0] vld_vec;

  assign busy       = (st_q != S_IDLE);
  assign host_wr    = wr_en && !busy;
  assign start_evt  = host_wr && (addr == A_OP) && wr_data[15];
  assign commit_evt = (st_q == S_DONE);

  assign load_wr   = commit_evt && (opc_q == OPC_LOAD) && vflag_q && (match_hit || free_hit);
  assign purge_wr  = commit_evt && (opc_q == OPC_LOAD) && !vflag_q && match_hit;
  assign full_set  = commit_evt && (opc_q == OPC_LOAD) && vflag_q && !match_hit && !free_hit;
  assign flush_evt = commit_evt && (opc_q == OPC_FLUSH);
  assign next_hit  = commit_evt && (opc_q == OPC_NEXT) && best_hit;
  assign next_miss = commit_evt && (opc_q == OPC_NEXT) && !best_hit;
  assign wr_idx    = match_hit ? match_idx : free_idx;
  assign rd_idx    = commit_evt ? best_idx : idx_q;

  // sequencer: scanning ops visit every slot, the rest commit at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_evt) begin
          idx_q <= '0;
          st_q  <= ((wr_data[14:12] == OPC_LOAD) || (wr_data[14:12] == OPC_NEXT))
                   ? S_SCAN : S_DONE;
        end
        S_SCAN: begin
          if (idx_q == IW'(DEPTH - 1)) st_q <= S_DONE;
          else                          idx_q <= idx_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0; db_q <= '0; vid_q <= '0; vflag_q <= 1'b0;
      data_q <= '0; full_q <= 1'b0;
    end else begin
      if (host_wr) begin
        if (addr == A_OP) begin
          opc_q <= wr_data[14:12];
          db_q  <= db_from_op(wr_data);
        end
        if (addr == A_VID) begin
          vid_q   <= vid_from_reg(wr_data);
          vflag_q <= wr_data[12];
        end
        for (int g = 0; g < NDREG; g++)
          if (addr == 3'(A_DATA + g)) data_q[g*REGW +: REGW] <= wr_data;
      end
      if (next_hit) begin
        vid_q   <= best_vid;
        vflag_q <= 1'b1;
        db_q    <= e_db;
        data_q  <= e_dat;
      end
      if (next_miss) begin
        vid_q   <= VID_WALK;
        vflag_q <= 1'b0;
      end
      if (full_set)                  full_q <= 1'b1;
      else if (load_wr || flush_evt) full_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_OP)
      rd_data = {busy, opc_q, 12'h000} | db_to_op(db_q) | {11'h0, full_q, 4'h0};
    if (rd_addr == A_VID)
      rd_data = vid_to_reg(vid_q, vflag_q);
    for (int g = 0; g < NDREG; g++)
      if (rd_addr == 3'(A_DATA + g)) rd_data = data_q[g*REGW +: REGW];
  end

  vlan_tbl_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(flush_evt),
    .we(load_wr || purge_wr), .wr_idx(wr_idx), .wr_vld(load_wr),
    .wr_vid(vid_q), .wr_db(db_q), .wr_dat(data_q),
    .rd_idx(rd_idx), .rd_vld(e_vld), .rd_vid(e_vid), .rd_db(e_db), .rd_dat(e_dat),
    .vld_vec(vld_vec)
  );

  vlan_tbl_scan #(.DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(start_evt), .step(st_q == S_SCAN),
    .idx(idx_q), .e_vld(e_vld), .e_vid(e_vid), .key(vid_q),
    .match_hit(match_hit), .match_idx(match_idx),
    .free_hit(free_hit), .free_idx(free_idx),
    .best_hit(best_hit), .best_idx(best_idx), .best_vid(best_vid)
  );
endmodule

// File: rtl/vlan_tbl_chk.sv
module vlan_tbl_chk #(
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             busy,
  input logic             start_evt,
  input logic             commit_evt,
  input logic             flush_evt,
  input logic             full_set,
  input logic             purge_wr,
  input logic [IW-1:0]    wr_idx,
  input logic [DEPTH-1:0] vld_vec,
  input logic [12:0]      vid_q
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !busy);
  // R10
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_evt && wr_en) |=> $stable(vid_q));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (vld_vec == '0));
  // R8
  full_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_set |-> (&vld_vec));
  // R6
  purge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_wr |=> !vld_vec[$past(wr_idx)]);
endmodule

bind vlan_tbl vlan_tbl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .start_evt(start_evt), .commit_evt(commit_evt), .flush_evt(flush_evt),
  .full_set(full_set), .purge_wr(purge_wr), .wr_idx(wr_idx),
  .vld_vec(vld_vec), .vid_q(vid_q)
);

// File: tb/vlan_tbl_bench.sv
module vlan_tbl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vlan_tbl #(.DEPTH(4), .NPORT(12)) u_vlan_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // rows: {vid[12:0], db[7:0], data0[15:0]}
  localparam logic [36:0] VEC [4] = '{
    {13'h0123, 8'h5A, 16'h1111},
    {13'h1005, 8'hC3, 16'h2222},
    {13'h0010, 8'h01, 16'h3333},
    {13'h0800, 8'hFF, 16'h4444}
  };
  localparam int ORDER [4] = '{2, 0, 3, 1};

  function automatic logic [15:0] vreg(input logic [12:0] v, input logic f);
    return {2'b00, v[12], f, v[11:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic run_op(input logic [15:0] w);
    logic [15:0] v;
    int guard;
    reg_wr(3'd0, w | 16'h8000);
    reg_rd(3'd0, v);
    chk("R1 busy after start", {15'h0, v[15]}, 16'h1);
    guard = 0;
    while (v[15] && guard < 64) begin
      @(negedge clk);
      reg_rd(3'd0, v);
      guard++;
    end
    chk("R1 busy cleared", {15'h0, v[15]}, 16'h0);
  endtask

  function automatic logic [15:0] dbw(input logic [7:0] d);
    return {4'h0, d[7:4], 4'h0, d[3:0]};
  endfunction

  task automatic load(input logic [12:0] v, input logic [7:0] d, input logic [15:0] d0);
    reg_wr(3'd1, vreg(v, 1'b1));
    reg_wr(3'd2, d0);
    reg_wr(3'd3, ~d0);
    reg_wr(3'd4, d0 ^ 16'h5A5A);
    run_op(16'h3000 | dbw(d));
  endtask

  task automatic next_from(input logic [12:0] key);
    reg_wr(3'd1, vreg(key, 1'b0));
    run_op(16'h4000);
  endtask

  task automatic expect_hit(input string req, input logic [12:0] v,
                            input logic [7:0] d, input logic [15:0] d0);
    logic [15:0] r;
    reg_rd(3'd1, r); chk(req, r, vreg(v, 1'b1));
    reg_rd(3'd0, r); chk(req, r & 16'h0F0F, dbw(d));
    reg_rd(3'd2, r); chk(req, r, d0);
    reg_rd(3'd3, r); chk(req, r, ~d0);
    reg_rd(3'd4, r); chk(req, r, d0 ^ 16'h5A5A);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    reg_rd(3'd0, r); chk("R2 reset op", r, 16'h0000);
    reg_rd(3'd1, r); chk("R2 reset vid", r, 16'h0000);
    reg_rd(3'd3, r); chk("R2 reset data", r, 16'h0000);

    // R6 load table rows, then R3/R4/R2 walk from the start key
    for (int i = 0; i < 4; i++) load(VEC[i][36:24], VEC[i][23:16], VEC[i][15:0]);
    reg_wr(3'd1, vreg(13'h0FFF, 1'b0));
    for (int i = 0; i < 4; i++) begin
      run_op(16'h4000);
      expect_hit("R3 R4 walk", VEC[ORDER[i]][36:24], VEC[ORDER[i]][23:16], VEC[ORDER[i]][15:0]);
    end
    run_op(16'h4000);
    reg_rd(3'd1, r); chk("R5 end of walk", r, 16'h0FFF);

    // R3 strictly greater
    next_from(13'h0200);
    reg_rd(3'd1, r); chk("R3 from 0x200", r, vreg(13'h0800, 1'b1));
    next_from(13'h0800);
    reg_rd(3'd1, r); chk("R3 strict from 0x800", r, vreg(13'h1005, 1'b1));

    // R8 full table rejects a new VID
    load(13'h0050, 8'h99, 16'h7777);
    reg_rd(3'd0, r); chk("R8 full flag set", r & 16'h0010, 16'h0010);
    next_from(13'h004F);
    reg_rd(3'd1, r); chk("R8 table unchanged", r, vreg(13'h0123, 1'b1));

    // R7 overwrite in place, clears full (R8)
    load(13'h0123, 8'h77, 16'hABCD);
    reg_rd(3'd0, r); chk("R8 full cleared", r & 16'h0010, 16'h0000);
    next_from(13'h0122);
    expect_hit("R7 overwrite", 13'h0123, 8'h77, 16'hABCD);
    run_op(16'h4000);
    reg_rd(3'd1, r); chk("R7 no duplicate", r, vreg(13'h0800, 1'b1));

    // R6 purge then reuse slot
    reg_wr(3'd1, vreg(13'h0800, 1'b0));
    run_op(16'h3000);
    next_from(13'h07FF);
    reg_rd(3'd1, r); chk("R6 purged", r, vreg(13'h1005, 1'b1));
    load(13'h0050, 8'h99, 16'h7777);
    reg_rd(3'd0, r); chk("R6 load into free slot", r & 16'h0010, 16'h0000);
    next_from(13'h004F);
    expect_hit("R6 reused slot", 13'h0050, 8'h99, 16'h7777);

    // R10 writes during busy ignored
    reg_wr(3'd1, vreg(13'h0FFF, 1'b0));
    reg_wr(3'd0, 16'hC000);
    reg_wr(3'd1, vreg(13'h0900, 1'b0));
    reg_rd(3'd0, r); chk("R10 still busy", {15'h0, r[15]}, 16'h1);
    repeat (8) @(negedge clk);
    reg_rd(3'd1, r); chk("R10 vid write ignored", r, vreg(13'h0010, 1'b1));
    next_from(13'h1005);
    reg_rd(3'd1, r); chk("R5 miss above top", r, 16'h0FFF);
    reg_wr(3'd0, 16'hC000);
    reg_wr(3'd2, 16'hDEAD);
    repeat (8) @(negedge clk);
    reg_rd(3'd2, r); chk("R10 data write ignored", r, 16'h3333);

    // R11 unsupported code leaves table intact
    run_op(16'h7000);
    next_from(13'h0FFF);
    reg_rd(3'd1, r); chk("R11 table intact", r, vreg(13'h0010, 1'b1));

    // R9 flush
    run_op(16'h1000);
    next_from(13'h0FFF);
    reg_rd(3'd1, r); chk("R9 flush empties", r, 16'h0FFF);
    next_from(13'h0000);
    reg_rd(3'd1, r); chk("R9 flush empties low key", r, 16'h0FFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule